// File: doc/BRIEF.md
# Response Ring Dispatcher

This block empties a circular ring of codec responses that a separate fetch engine fills in memory. The ring has 256 slots. Each slot holds two 32-bit words: first the response payload, then an extended word. The extended word carries the responding codec's address and a flag that marks an unsolicited event. The block compares its own read pointer with the write pointer that hardware reports. Whenever they differ, it advances its pointer, reads the slot through a one-cycle-latency word port and sorts the entry into one of three classes.

The three classes are handled as follows:
- **Unsolicited event:** the entry is forwarded on an event stream.
- **Solicited response:** the entry is matched against a per-codec count of commands still awaiting an answer. The payload becomes that codec's result and the count drops by one.
- **Spurious:** any entry that cannot be matched raises a one-cycle flag.

The command side pulses an increment for each command it issues. A codec's done line is high when nothing is outstanding for it, and its result is presented only in that state. A write-pointer reading of all ones means the ring's owner is powered down, and nothing is fetched.

Top module: `rsp_ring_dispatch`

## Requirements
- R1: After reset the read pointer is 0, every outstanding count is 0, all done lines are high, every result port reads 0, and no event or spurious pulse is given.
- R2: The read pointer is advanced (modulo 256) before a slot is read. Slot k is read as word address 2k (payload) in one cycle, then word address 2k+1 (extended word) in the next cycle. Read data returns one cycle after the read request.
- R3: Draining continues while the read pointer differs from bits 7:0 of the write pointer, and the pointer wraps from 255 to 0.
- R4: While the 16-bit write pointer reads 0xFFFF, no read is requested and no entry is processed.
- R5: Bits 3:0 of the extended word give the codec address. An address at or above NUM_CODEC (default 8) gives a one-cycle spurious pulse, even when bit 4 is set, and changes no count or result.
- R6: An entry with extended-word bit 4 set and an in-range address gives a one-cycle event pulse carrying both words, and changes no count or result.
- R7: A solicited entry (bit 4 clear) for a codec with a non-zero count stores the payload as that codec's result and decrements its count.
- R8: A solicited entry for a codec whose count is zero gives a spurious pulse and leaves that codec's result unchanged.
- R9: A command pulse increments the addressed codec's count. The count saturates at its maximum (255 by default), and a pulse for an address at or above NUM_CODEC changes nothing.
- R10: An increment and a decrement on the same codec in the same cycle leave its count unchanged.
- R11: done_o[c] is high exactly when codec c's count is zero. While the count is non-zero, that codec's result port reads 0.
- R12: Each entry gives exactly one outcome (event, result update or spurious pulse), and each entry takes four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_wp_i | input | 16 | Hardware write pointer reading; all ones means powered down |
| rd_en_o | output | 1 | Ring word read request |
| rd_addr_o | output | 9 | Ring word address (2·slot, 2·slot+1) |
| rd_data_i | input | 32 | Ring word, one cycle after the request |
| cmd_valid_i | input | 1 | One command issued this cycle |
| cmd_codec_i | input | 4 | Codec address of the issued command |
| evt_valid_o | output | 1 | Unsolicited event pulse |
| evt_rsp_o | output | 32 | Event payload word |
| evt_ext_o | output | 32 | Event extended word |
| spur_o | output | 1 | Spurious entry pulse |
| done_o | output | 8 | Per-codec nothing-outstanding status |
| res_o | output | 256 | Per-codec result, codec c at bits 32c+31:32c |

## Verification
The assertions watch the fetch sequence on every cycle. They check that the payload read is always followed by the extended-word read of the same slot, that the pointer moves by at most one step, and that nothing is fetched while the write pointer reads all ones. They also check that an out-of-range address always ends as a spurious pulse, that a decrement never meets a zero count, and that a simultaneous increment and decrement hold the count. The following behaviours need the bench's directed scenarios, because each depends on a chosen ring content and on counts built up over time:
- routing of each entry class to the right output;
- a result staying hidden until its last answer arrives;
- saturation of a count;
- the wrap of the pointer through slot 0.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

   // Fixed field positions inside the extended word; the classifier decodes them.
   localparam int CODEC_AW      = 4;
   localparam int UNSOL_BIT     = 4;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_RSP  = 2'd1,
      WK_EXT  = 2'd2,
      WK_DISP = 2'd3
   } walk_state_e;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_SOL   = 2'd1,
      CLS_UNSOL = 2'd2,
      CLS_SPUR  = 2'd3
   } entry_class_e;

endpackage

// File: rtl/rrd_ring_walker.sv
module rrd_ring_walker
   import rrd_pkg::*;
#(
   parameter int RING_DEPTH = 256,
   parameter int WORD_W     = 32,
   parameter int WP_W       = 16,
   localparam int PTR_W     = $clog2(RING_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WP_W-1:0]   hw_wp_i,
   output logic              rd_en_o,
   output logic [PTR_W:0]    rd_addr_o,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic              disp_o,
   output logic [WORD_W-1:0] rsp_o,
   output logic [WORD_W-1:0] ext_o
);

   localparam logic [WP_W-1:0] PWR_DOWN_MARK = {WP_W{1'b1}};

   walk_state_e       state_q;
   logic [PTR_W-1:0]  rp_q;
   logic [WORD_W-1:0] rsp_q;
   logic              pwr_down;
   logic              pending;

   assign pwr_down = (hw_wp_i == PWR_DOWN_MARK);
   assign pending  = (hw_wp_i[PTR_W-1:0] != rp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         rp_q    <= '0;
         rsp_q   <= '0;
      end else begin
         unique case (state_q)
            WK_IDLE: begin
               // pointer advances before the slot is fetched
               if (!pwr_down && pending) begin
                  rp_q    <= rp_q + 1'b1;
                  state_q <= WK_RSP;
               end
            end
            WK_RSP:  state_q <= WK_EXT;
            WK_EXT: begin
               rsp_q   <= rd_data_i;
               state_q <= WK_DISP;
            end
            WK_DISP: state_q <= WK_IDLE;
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   assign rd_en_o   = (state_q == WK_RSP) || (state_q == WK_EXT);
   assign rd_addr_o = {rp_q, (state_q == WK_EXT)};
   assign disp_o    = (state_q == WK_DISP);
   assign rsp_o     = rsp_q;
   assign ext_o     = rd_data_i;

   // R2: a payload read is always followed by the extended word of the same slot
   a_r2_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_RSP) |=> (rd_en_o && rd_addr_o == {$past(rd_addr_o[PTR_W:1]), 1'b1}));

   // R3: the read pointer moves by at most one step per cycle
   a_r3_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != WK_IDLE) |=> (rp_q == $past(rp_q)));

   // R4: nothing is fetched while the pointer reading says powered down
   a_r4_no_fetch_down: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_IDLE && pwr_down) |=> (!rd_en_o && state_q == WK_IDLE));

endmodule

// File: rtl/rrd_classify.sv
module rrd_classify
   import rrd_pkg::*;
#(
   parameter int NUM_CODEC = 8
) (
   input  logic                 disp_i,
   input  logic [UNSOL_BIT:0]   ext_i,
   input  logic [NUM_CODEC-1:0] pend_i,
   output entry_class_e         cls_o,
   output logic [CODEC_AW-1:0]  codec_o
);

   logic [(1<<CODEC_AW)-1:0] pend_w;
   logic                     out_of_range;

   always_comb begin
      pend_w                  = '0;
      pend_w[NUM_CODEC-1:0]   = pend_i;
   end

   assign codec_o      = ext_i[CODEC_AW-1:0];
   assign out_of_range = ({1'b0, codec_o} >= (CODEC_AW+1)'(NUM_CODEC));

   // Priority: address range first, then the unsolicited flag, then the count.
   always_comb begin
      cls_o = CLS_NONE;
      if (disp_i) begin
         if (out_of_range)
            cls_o = CLS_SPUR;
         else if (ext_i[UNSOL_BIT])
            cls_o = CLS_UNSOL;
         else if (pend_w[codec_o])
            cls_o = CLS_SOL;
         else
            cls_o = CLS_SPUR;
      end
   end

endmodule

// File: rtl/rrd_codec_track.sv
module rrd_codec_track #(
   parameter int CNT_W  = 8,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              dec_i,
   input  logic [WORD_W-1:0] rsp_i,
   output logic              done_o,
   output logic [WORD_W-1:0] res_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         res_q <= '0;
      end else begin
         if (dec_i)
            res_q <= rsp_i;
         unique case ({inc_i, dec_i})
            2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
      end
   end

   assign done_o = (cnt_q == '0);
   // result is only presented once every outstanding command is answered
   assign res_o  = done_o ? res_q : '0;

   // R10: simultaneous increment and decrement hold the count
   a_r10_inc_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && dec_i) |=> (cnt_q == $past(cnt_q)));

   // R7: a decrement is only ever issued against a non-zero count
   a_r7_dec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> (cnt_q != '0));

endmodule

// File: rtl/rsp_ring_dispatch.sv
module rsp_ring_dispatch
   import rrd_pkg::*;
#(
   parameter int RING_DEPTH = 256,
   parameter int NUM_CODEC  = 8,
   parameter int WORD_W     = 32,
   parameter int CNT_W      = 8,
   parameter int WP_W       = 16,
   localparam int PTR_W     = $clog2(RING_DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [WP_W-1:0]             hw_wp_i,
   output logic                        rd_en_o,
   output logic [PTR_W:0]              rd_addr_o,
   input  logic [WORD_W-1:0]           rd_data_i,
   input  logic                        cmd_valid_i,
   input  logic [CODEC_AW-1:0]         cmd_codec_i,
   output logic                        evt_valid_o,
   output logic [WORD_W-1:0]           evt_rsp_o,
   output logic [WORD_W-1:0]           evt_ext_o,
   output logic                        spur_o,
   output logic [NUM_CODEC-1:0]        done_o,
   output logic [NUM_CODEC*WORD_W-1:0] res_o
);

   // elaboration-time parameter checks
   if ((1 << PTR_W) != RING_DEPTH || RING_DEPTH < 2) begin : g_bad_depth
      $error("RING_DEPTH must be a power of two of at least 2");
   end
   if (NUM_CODEC < 1 || NUM_CODEC > (1 << CODEC_AW)) begin : g_bad_codec
      $error("NUM_CODEC must lie between 1 and 16");
   end
   if (WORD_W <= UNSOL_BIT || PTR_W >= WP_W || CNT_W < 1) begin : g_bad_width
      $error("WORD_W, WP_W or CNT_W too small");
   end

   logic                 disp;
   logic [WORD_W-1:0]    w_rsp;
   logic [WORD_W-1:0]    w_ext;
   entry_class_e         cls;
   logic [CODEC_AW-1:0]  codec;
   logic [NUM_CODEC-1:0] inc_vec;
   logic [NUM_CODEC-1:0] dec_vec;
   logic [NUM_CODEC-1:0] done_vec;

   rrd_ring_walker #(
      .RING_DEPTH (RING_DEPTH),
      .WORD_W     (WORD_W),
      .WP_W       (WP_W)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_wp_i   (hw_wp_i),
      .rd_en_o   (rd_en_o),
      .rd_addr_o (rd_addr_o),
      .rd_data_i (rd_data_i),
      .disp_o    (disp),
      .rsp_o     (w_rsp),
      .ext_o     (w_ext)
   );

   rrd_classify #(
      .NUM_CODEC (NUM_CODEC)
   ) u_classify (
      .disp_i  (disp),
      .ext_i   (w_ext[UNSOL_BIT:0]),
      .pend_i  (~done_vec),
      .cls_o   (cls),
      .codec_o (codec)
   );

   for (genvar c = 0; c < NUM_CODEC; c++) begin : g_codec
      assign inc_vec[c] = cmd_valid_i && (cmd_codec_i == CODEC_AW'(c));
      assign dec_vec[c] = (cls == CLS_SOL) && (codec == CODEC_AW'(c));

      rrd_codec_track #(
         .CNT_W  (CNT_W),
         .WORD_W (WORD_W)
      ) u_track (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc_i  (inc_vec[c]),
         .dec_i  (dec_vec[c]),
         .rsp_i  (w_rsp),
         .done_o (done_vec[c]),
         .res_o  (res_o[c*WORD_W +: WORD_W])
      );
   end

   assign done_o = done_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_valid_o <= 1'b0;
         evt_rsp_o   <= '0;
         evt_ext_o   <= '0;
         spur_o      <= 1'b0;
      end else begin
         evt_valid_o <= (cls == CLS_UNSOL);
         spur_o      <= (cls == CLS_SPUR);
         if (cls == CLS_UNSOL) begin
            evt_rsp_o <= w_rsp;
            evt_ext_o <= w_ext;
         end
      end
   end

   // R5: an out-of-range address always ends as a spurious pulse, never as an event
   a_r5_range_spur: assert property (@(posedge clk) disable iff (!rst_n)
      (disp && ({1'b0, w_ext[CODEC_AW-1:0]} >= (CODEC_AW+1)'(NUM_CODEC)))
      |=> (spur_o && !evt_valid_o));

   // R12: an event pulse and a spurious pulse never coincide
   a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_valid_o, spur_o}));

endmodule

// File: tb/rsp_ring_dispatch_tb.sv
`timescale 1ns/1ps
module rsp_ring_dispatch_tb;

   localparam int NC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   hw_wp = 16'h0;
   logic          rd_en;
   logic [8:0]    rd_addr;
   logic [31:0]   rd_data = 32'h0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_codec = 4'h0;
   logic          evt_valid;
   logic [31:0]   evt_rsp, evt_ext;
   logic          spur;
   logic [NC-1:0] done;
   logic [NC*32-1:0] res;

   logic [31:0] mem [0:511];

   int n_chk = 0, n_err = 0;
   int rd_cnt = 0, evt_cnt = 0, spur_cnt = 0;
   logic [31:0] last_evt_rsp = 0, last_evt_ext = 0;
   logic [8:0]  prev_addr = 0, last_addr = 0;
   bit          seen0 = 0;
   bit          finished = 0;
   logic [7:0]  b_rp = 8'h0;
   int          n_entries = 0;

   always #2 clk = ~clk;

   rsp_ring_dispatch u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_wp_i     (hw_wp),
      .rd_en_o     (rd_en),
      .rd_addr_o   (rd_addr),
      .rd_data_i   (rd_data),
      .cmd_valid_i (cmd_valid),
      .cmd_codec_i (cmd_codec),
      .evt_valid_o (evt_valid),
      .evt_rsp_o   (evt_rsp),
      .evt_ext_o   (evt_ext),
      .spur_o      (spur),
      .done_o      (done),
      .res_o       (res)
   );

   // ring memory with one cycle of read latency
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   // observation away from the active edge
   always @(negedge clk) begin
      if (rd_en) begin
         rd_cnt++;
         prev_addr = last_addr;
         last_addr = rd_addr;
         if (rd_addr == 9'd0) seen0 = 1;
      end
      if (evt_valid) begin
         evt_cnt++;
         last_evt_rsp = evt_rsp;
         last_evt_ext = evt_ext;
      end
      if (spur) spur_cnt++;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] res_of(input int c);
      return res[c*32 +: 32];
   endfunction

   task automatic post(input logic [31:0] rsp, input logic [31:0] ext);
      b_rp = b_rp + 8'd1;
      mem[{b_rp, 1'b0}] = rsp;
      mem[{b_rp, 1'b1}] = ext;
      n_entries++;
   endtask

   task automatic kick(input int n);
      @(negedge clk) hw_wp = {8'h00, b_rp};
      repeat (4*n + 4) @(negedge clk);
   endtask

   task automatic send_cmd(input logic [3:0] c);
      @(negedge clk) begin cmd_valid = 1'b1; cmd_codec = c; end
      @(negedge clk) cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      check(done == {NC{1'b1}}, "R1 done after reset", done, {NC{1'b1}});
      check(res == '0, "R1 results after reset", res[63:0], 0);
      check(evt_cnt == 0 && spur_cnt == 0 && rd_cnt == 0, "R1 quiet after reset", rd_cnt, 0);
   endtask

   task automatic t_solicited();
      send_cmd(4'd3);
      send_cmd(4'd3);
      check(done[3] == 1'b0, "R9 count raised", done[3], 0);
      post(32'hA0A0_0001, 32'h3);
      kick(1);
      check(prev_addr == {b_rp, 1'b0} && last_addr == {b_rp, 1'b1}, "R2 word order",
            {prev_addr, last_addr}, {b_rp, 1'b0, b_rp, 1'b1});
      check(b_rp == 8'd1 && prev_addr == 9'd2, "R2 pointer advanced before read", prev_addr, 2);
      check(done[3] == 1'b0 && res_of(3) == 32'h0, "R11 result hidden while outstanding", res_of(3), 0);
      post(32'hB0B0_0002, 32'h3);
      kick(1);
      check(done[3] == 1'b1, "R11 done after last answer", done[3], 1);
      check(res_of(3) == 32'hB0B0_0002, "R7 latest result stored", res_of(3), 32'hB0B0_0002);
   endtask

   task automatic t_unsol();
      int e0;
      e0 = evt_cnt;
      send_cmd(4'd2);
      post(32'hC0C0_0003, 32'h12);
      kick(1);
      check(evt_cnt == e0 + 1, "R6 event pulse", evt_cnt, e0 + 1);
      check(last_evt_rsp == 32'hC0C0_0003 && last_evt_ext == 32'h12, "R6 event words",
            last_evt_rsp, 32'hC0C0_0003);
      check(done[2] == 1'b0 && res_of(2) == 0, "R6 count untouched by event", done[2], 0);
      post(32'hD0D0_0004, 32'h2);
      kick(1);
      check(done[2] == 1'b1 && res_of(2) == 32'hD0D0_0004, "R7 answer after event", res_of(2), 32'hD0D0_0004);
   endtask

   task automatic t_spurious();
      int s0, e0;
      s0 = spur_cnt; e0 = evt_cnt;
      post(32'hE0E0_0005, 32'h5);
      kick(1);
      check(spur_cnt == s0 + 1, "R8 zero-count answer spurious", spur_cnt, s0 + 1);
      check(res_of(5) == 0 && done[5] == 1'b1, "R8 result unchanged", res_of(5), 0);
      post(32'hF0F0_0006, 32'h1A);
      kick(1);
      check(spur_cnt == s0 + 2 && evt_cnt == e0, "R5 out-of-range spurious even if unsolicited",
            spur_cnt, s0 + 2);
      check(done == {NC{1'b1}} && res_of(2) == 32'hD0D0_0004, "R5 no state touched", done, {NC{1'b1}});
   endtask

   task automatic t_same_cycle();
      int s0;
      s0 = spur_cnt;
      send_cmd(4'd1);
      post(32'h1111_0007, 32'h1);
      @(negedge clk) hw_wp = {8'h00, b_rp};
      @(negedge clk);
      @(negedge clk);
      @(negedge clk) begin cmd_valid = 1'b1; cmd_codec = 4'd1; end
      @(negedge clk) cmd_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(done[1] == 1'b0, "R10 inc and dec together hold count", done[1], 0);
      post(32'h2222_0008, 32'h1);
      kick(1);
      check(done[1] == 1'b1 && spur_cnt == s0 && res_of(1) == 32'h2222_0008,
            "R10 remaining command answered", res_of(1), 32'h2222_0008);
   endtask

   task automatic t_power_down();
      int r0;
      r0 = rd_cnt;
      @(negedge clk) hw_wp = 16'hFFFF;
      repeat (20) @(negedge clk);
      check(rd_cnt == r0, "R4 no read while powered down", rd_cnt, r0);
      @(negedge clk) hw_wp = {8'h00, b_rp};
      repeat (8) @(negedge clk);
      check(rd_cnt == r0, "R3 no read when pointers equal", rd_cnt, r0);
   endtask

   task automatic t_range_cmd();
      send_cmd(4'd12);
      check(done == {NC{1'b1}}, "R9 out-of-range command ignored", done, {NC{1'b1}});
   endtask

   task automatic t_saturate_wrap();
      int s0;
      s0 = spur_cnt;
      @(negedge clk) begin cmd_valid = 1'b1; cmd_codec = 4'd6; end
      repeat (256) @(negedge clk);
      cmd_valid = 1'b0;
      check(done[6] == 1'b0, "R9 count saturates instead of wrapping", done[6], 0);
      for (int i = 0; i < 254; i++) post(32'h6000_0000 + i, 32'h6);
      kick(254);
      check(done[6] == 1'b0, "R9 one answer still owed at saturation", done[6], 0);
      post(32'h6000_00FE, 32'h6);
      kick(1);
      check(done[6] == 1'b1 && res_of(6) == 32'h6000_00FE, "R9 saturated count drained",
            res_of(6), 32'h6000_00FE);
      check(spur_cnt == s0, "R12 no spurious during drain", spur_cnt, s0);
      check(seen0 == 1'b1, "R3 pointer wrapped through slot 0", seen0, 1);
      check(rd_cnt == 2*n_entries, "R12 two reads per entry", rd_cnt, 2*n_entries);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_solicited();
      t_unsol();
      t_spurious();
      t_same_cycle();
      t_power_down();
      t_range_cmd();
      t_saturate_wrap();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule